// File: doc/BRIEF.md
# Audio Master Clock Divider Network

This block turns one fast synthesiser clock into the clocks an audio subsystem needs. Two even-ratio dividers run from the fast clock: a system clock and an audio clock. The audio clock is the candidate for the audio master clock output. A two-bit rate mode sets a base factor (1, 2, 4 or 6). A two-bit system select and a one-bit audio select shift that base to reach the final ratios, some of which are not powers of two.

The master clock output comes from a glitch-free switch that picks either the audio clock or the free-running oscillator clock. It is driven only when the block is set to master. A second glitch-free switch picks either the system clock or the oscillator for an auxiliary clock pin. All control inputs are static register-style levels. A change to a divide select waits for the current half period to finish, so no runt pulse appears.

Top module: `mclk_divnet`

## Requirements
- R1: While rstN is low, sysClkOut, audClkOut, mclkOut, auxClkOut and mclkOe are all low.
- R2: The audio clock divides synthClk by 2, 4, 8 or 12 for rateMode 0, 1, 2 or 3 when audDivSel is 0, and by twice that (4, 8, 16, 24) when audDivSel is 1.
- R3: The system clock divides synthClk by base shifted left by sysDivSel, with base 1, 2, 4, 6 for rateMode 0 to 3 and a floor of 2. This gives 2/2/4/8, 2/4/8/16, 4/8/16/32 and 6/12/24/48.
- R4: Both divided clocks have a 50% duty cycle: high and low phases each last half the divide factor in synthClk cycles.
- R5: A change to a divide select lets the phase in progress finish at its old length. The new length applies from the next phase.
- R6: With masterMode 0, mclkOe is low and mclkOut stays low from the second synthClk edge after the change. With masterMode 1, mclkOe is high.
- R7: In master mode with mclkSrcOsc 0, mclkOut has the audio clock's period.
- R8: In master mode with mclkSrcOsc 1, mclkOut follows oscClk level for level once the switch has settled, and audDivSel has no effect on it.
- R9: auxClkOut carries the system clock when auxSrcOsc is 0 and follows oscClk when auxSrcOsc is 1.
- R10: Switching the mclkOut source never produces a high or low pulse shorter than the shorter half period of the two sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| synthClk | input | 1 | Fast synthesiser clock that drives both dividers |
| oscClk | input | 1 | Free-running oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateMode | input | 2 | Selects the base factor (1, 2, 4, 6) |
| sysDivSel | input | 2 | Shift applied to the system clock factor |
| audDivSel | input | 1 | Shift applied to the audio clock factor |
| mclkSrcOsc | input | 1 | Master clock source: 0 audio clock, 1 oscillator |
| auxSrcOsc | input | 1 | Auxiliary clock source: 0 system clock, 1 oscillator |
| masterMode | input | 1 | 1 drives mclkOut, 0 leaves it disabled |
| sysClkOut | output | 1 | Divided system clock |
| audClkOut | output | 1 | Divided audio clock |
| mclkOut | output | 1 | Master clock output, low when not driven |
| mclkOe | output | 1 | Master clock output enable |
| auxClkOut | output | 1 | Auxiliary clock output |

## Verification
A wrong half-count or a bad ratio lookup shows up as a wrong phase length on sysClkOut or audClkOut. That is visible within one output period, at most 48 synthClk cycles. A divider that reloads its count mid-phase cuts the phase in progress short in the same cycle as the select change. A broken source switch shows up within a few oscillator cycles, either as a pulse narrower than either source's half period or as mclkOut failing to track oscClk. A wrong drive enable leaves mclkOut toggling two edges after master mode is cleared.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;
  localparam int MAX_FACTOR = 48;
  localparam int RAW_W      = $clog2(MAX_FACTOR + 1);
  localparam int HALF_W     = $clog2(MAX_FACTOR / 2 + 1);

  typedef struct packed {
    logic [HALF_W-1:0] sysHalf;
    logic [HALF_W-1:0] audHalf;
    logic              mclkPickOsc;
    logic              auxPickOsc;
    logic              drive;
  } div_cmd_t;
endpackage

// File: rtl/mclk_div_ctrl.sv
module mclk_div_ctrl
  import mclk_div_pkg::*;
(
  input  logic [1:0] rateMode,
  input  logic [1:0] sysDivSel,
  input  logic       audDivSel,
  input  logic       mclkSrcOsc,
  input  logic       auxSrcOsc,
  input  logic       masterMode,
  output div_cmd_t   cmd
);
  logic [RAW_W-1:0] base;
  logic [RAW_W-1:0] sysFactor;
  logic [RAW_W-1:0] audHalfRaw;

  always_comb begin
    // base factor: powers of two for the first three modes, six for the last
    base       = (rateMode == 2'd3) ? RAW_W'(6) : (RAW_W'(1) << rateMode);
    sysFactor  = base << sysDivSel;
    audHalfRaw = base << audDivSel;
    cmd.sysHalf     = (sysFactor < RAW_W'(2)) ? HALF_W'(1) : HALF_W'(sysFactor >> 1);
    cmd.audHalf     = HALF_W'(audHalfRaw);
    cmd.mclkPickOsc = mclkSrcOsc;
    cmd.auxPickOsc  = auxSrcOsc;
    cmd.drive       = masterMode;
  end
endmodule

// File: rtl/mclk_div_counter.sv
module mclk_div_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] half,
  output logic         divClk
);
  logic [W-1:0] cnt;
  logic [W-1:0] halfReg;

  // the requested half count is taken only when a phase ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      halfReg <= W'(1);
      divClk  <= 1'b0;
    end else if (cnt == halfReg - W'(1)) begin
      cnt     <= '0;
      halfReg <= half;
      divClk  <= ~divClk;
    end else begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/mclk_clk_switch.sv
module mclk_clk_switch (
  input  logic clkA,
  input  logic clkB,
  input  logic rstN,
  input  logic pickB,
  output logic clkSel
);
  logic [1:0] syncA;
  logic [1:0] syncB;

  // each leg arms only once the other leg has released, on its own falling edge
  always_ff @(negedge clkA or negedge rstN) begin
    if (!rstN) syncA <= '0;
    else       syncA <= {syncA[0], ~pickB & ~syncB[1]};
  end

  always_ff @(negedge clkB or negedge rstN) begin
    if (!rstN) syncB <= '0;
    else       syncB <= {syncB[0], pickB & ~syncA[1]};
  end

  assign clkSel = (clkA & syncA[1]) | (clkB & syncB[1]);
endmodule

// File: rtl/mclk_div_datapath.sv
module mclk_div_datapath
  import mclk_div_pkg::*;
(
  input  logic     synthClk,
  input  logic     oscClk,
  input  logic     rstN,
  input  div_cmd_t cmd,
  output logic     sysClkOut,
  output logic     audClkOut,
  output logic     mclkOut,
  output logic     mclkOe,
  output logic     auxClkOut
);
  logic [1:0][HALF_W-1:0] halves;
  logic [1:0]             divClk;
  logic                   mclkSel;
  logic                   oeReg;

  assign halves[0] = cmd.sysHalf;
  assign halves[1] = cmd.audHalf;

  for (genvar g = 0; g < 2; g++) begin : g_div
    mclk_div_counter #(.W(HALF_W)) u_cnt (
      .clk    (synthClk),
      .rstN   (rstN),
      .half   (halves[g]),
      .divClk (divClk[g])
    );
  end

  mclk_clk_switch u_mclkSw (
    .clkA   (divClk[1]),
    .clkB   (oscClk),
    .rstN   (rstN),
    .pickB  (cmd.mclkPickOsc),
    .clkSel (mclkSel)
  );

  mclk_clk_switch u_auxSw (
    .clkA   (divClk[0]),
    .clkB   (oscClk),
    .rstN   (rstN),
    .pickB  (cmd.auxPickOsc),
    .clkSel (auxClkOut)
  );

  always_ff @(posedge synthClk or negedge rstN) begin
    if (!rstN) oeReg <= 1'b0;
    else       oeReg <= cmd.drive;
  end

  assign sysClkOut = divClk[0];
  assign audClkOut = divClk[1];
  assign mclkOe    = oeReg;
  assign mclkOut   = mclkSel & oeReg;
endmodule

// File: rtl/mclk_divnet.sv
module mclk_divnet
  import mclk_div_pkg::*;
(
  input  logic       synthClk,
  input  logic       oscClk,
  input  logic       rstN,
  input  logic [1:0] rateMode,
  input  logic [1:0] sysDivSel,
  input  logic       audDivSel,
  input  logic       mclkSrcOsc,
  input  logic       auxSrcOsc,
  input  logic       masterMode,
  output logic       sysClkOut,
  output logic       audClkOut,
  output logic       mclkOut,
  output logic       mclkOe,
  output logic       auxClkOut
);
  div_cmd_t cmd;

  mclk_div_ctrl u_ctrl (
    .rateMode   (rateMode),
    .sysDivSel  (sysDivSel),
    .audDivSel  (audDivSel),
    .mclkSrcOsc (mclkSrcOsc),
    .auxSrcOsc  (auxSrcOsc),
    .masterMode (masterMode),
    .cmd        (cmd)
  );

  mclk_div_datapath u_dp (
    .synthClk  (synthClk),
    .oscClk    (oscClk),
    .rstN      (rstN),
    .cmd       (cmd),
    .sysClkOut (sysClkOut),
    .audClkOut (audClkOut),
    .mclkOut   (mclkOut),
    .mclkOe    (mclkOe),
    .auxClkOut (auxClkOut)
  );
endmodule

// File: rtl/mclk_divnet_chk.sv
module mclk_divnet_chk (
  input logic synthClk,
  input logic rstN,
  input logic masterMode,
  input logic sysClkOut,
  input logic audClkOut,
  input logic mclkOut,
  input logic mclkOe,
  input logic auxClkOut
);
  logic       prevSys;
  logic       prevAud;
  logic [7:0] sysLen;
  logic [7:0] audLen;

  function automatic logic sysLegal(input logic [7:0] n);
    return n inside {8'd1, 8'd2, 8'd3, 8'd4, 8'd6, 8'd8, 8'd12, 8'd16, 8'd24};
  endfunction

  function automatic logic audLegal(input logic [7:0] n);
    return n inside {8'd1, 8'd2, 8'd4, 8'd6, 8'd8, 8'd12};
  endfunction

  // run length of the current level, counted in synthClk edges
  always_ff @(posedge synthClk or negedge rstN) begin
    if (!rstN) begin
      prevSys <= 1'b0;
      prevAud <= 1'b0;
      sysLen  <= '0;
      audLen  <= '0;
    end else begin
      prevSys <= sysClkOut;
      prevAud <= audClkOut;
      if (sysClkOut != prevSys)  sysLen <= 8'd1;
      else if (sysLen != 8'hFF)  sysLen <= sysLen + 8'd1;
      if (audClkOut != prevAud)  audLen <= 8'd1;
      else if (audLen != 8'hFF)  audLen <= audLen + 8'd1;
    end
  end

  always @(posedge synthClk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!sysClkOut && !audClkOut && !mclkOut && !mclkOe && !auxClkOut)
        else $error("outputs active during reset");
    end
  end

  assert_aud_phase_R2: assert property (@(posedge synthClk) disable iff (!rstN)
    (audClkOut != prevAud) |-> audLegal(audLen))
    else $error("audio clock phase length illegal");

  assert_sys_phase_R3: assert property (@(posedge synthClk) disable iff (!rstN)
    (sysClkOut != prevSys) |-> sysLegal(sysLen))
    else $error("system clock phase length illegal");

  assert_slave_oe_R6: assert property (@(posedge synthClk) disable iff (!rstN)
    !masterMode |=> !mclkOe)
    else $error("output enable high in slave mode");

  assert_slave_quiet_R6: assert property (@(posedge synthClk) disable iff (!rstN)
    !masterMode |=> !mclkOut)
    else $error("master clock toggling in slave mode");
endmodule

bind mclk_divnet mclk_divnet_chk u_chk (
  .synthClk   (synthClk),
  .rstN       (rstN),
  .masterMode (masterMode),
  .sysClkOut  (sysClkOut),
  .audClkOut  (audClkOut),
  .mclkOut    (mclkOut),
  .mclkOe     (mclkOe),
  .auxClkOut  (auxClkOut)
);

// File: tb/mclk_divnet_tb.sv
module mclk_divnet_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_HALF   = 7;

  logic       synthClk = 1'b0;
  logic       oscClk   = 1'b0;
  logic       rstN     = 1'b0;
  logic [1:0] rateMode = 2'd0;
  logic [1:0] sysDivSel = 2'd0;
  logic       audDivSel = 1'b0;
  logic       mclkSrcOsc = 1'b0;
  logic       auxSrcOsc = 1'b0;
  logic       masterMode = 1'b0;
  logic       sysClkOut, audClkOut, mclkOut, mclkOe, auxClkOut;

  int checks = 0;
  int errors = 0;

  bit  watchOn = 1'b0;
  bit  haveEdge = 1'b0;
  time lastEdge = 0;
  time minPulse = 0;

  always #(CLK_PERIOD / 2) synthClk = ~synthClk;
  always #(OSC_HALF) oscClk = ~oscClk;

  mclk_divnet u_dut (
    .synthClk   (synthClk),
    .oscClk     (oscClk),
    .rstN       (rstN),
    .rateMode   (rateMode),
    .sysDivSel  (sysDivSel),
    .audDivSel  (audDivSel),
    .mclkSrcOsc (mclkSrcOsc),
    .auxSrcOsc  (auxSrcOsc),
    .masterMode (masterMode),
    .sysClkOut  (sysClkOut),
    .audClkOut  (audClkOut),
    .mclkOut    (mclkOut),
    .mclkOe     (mclkOe),
    .auxClkOut  (auxClkOut)
  );

  always @(mclkOut) begin
    if (watchOn) begin
      if (haveEdge && ($time - lastEdge < minPulse)) minPulse = $time - lastEdge;
      lastEdge = $time;
      haveEdge = 1'b1;
    end
  end

  function automatic logic pick(input int w);
    case (w)
      0:       return sysClkOut;
      1:       return audClkOut;
      2:       return mclkOut;
      default: return auxClkOut;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one high phase then one low phase, in synthClk cycles
  task automatic measure(input int w, output int hi, output int lo);
    @(negedge synthClk);
    while (pick(w) !== 1'b0) @(negedge synthClk);
    while (pick(w) !== 1'b1) @(negedge synthClk);
    hi = 0;
    while (pick(w) === 1'b1) begin hi++; @(negedge synthClk); end
    lo = 0;
    while (pick(w) === 1'b0) begin lo++; @(negedge synthClk); end
  endtask

  task automatic settledMeasure(input int w, output int hi, output int lo);
    int dh, dl;
    measure(w, dh, dl);
    measure(w, hi, lo);
  endtask

  function automatic int sysFactor(input int m, input int s);
    int b = (m == 3) ? 6 : (1 << m);
    int f = b << s;
    return (f < 2) ? 2 : f;
  endfunction

  function automatic int audFactor(input int m, input int s);
    int b = (m == 3) ? 6 : (1 << m);
    return (b << s) * 2;
  endfunction

  task automatic followOsc(input int w, input bit flipAud, output int bad);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (flipAud && i == 10) audDivSel = ~audDivSel;
      @(posedge oscClk); #1;
      if (pick(w) !== 1'b1) bad++;
      @(negedge oscClk); #1;
      if (pick(w) !== 1'b0) bad++;
    end
  endtask

  task automatic testReset();
    int bad = 0;
    rstN = 1'b0;
    masterMode = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge synthClk);
      if (sysClkOut || audClkOut || mclkOut || mclkOe || auxClkOut) bad++;
    end
    check(bad == 0, "R1 outputs low in reset", bad, 0);
    @(negedge synthClk);
    rstN = 1'b1;
  endtask

  task automatic testSysSweep();
    int hi, lo, f;
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        rateMode = 2'(m);
        sysDivSel = 2'(s);
        f = sysFactor(m, s);
        settledMeasure(0, hi, lo);
        check(hi + lo == f, "R3 system clock period", hi + lo, f);
        check(hi == lo, "R4 system clock duty", hi, lo);
      end
    end
  endtask

  task automatic testAudSweep();
    int hi, lo, f, mh, ml;
    masterMode = 1'b1;
    mclkSrcOsc = 1'b0;
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        rateMode = 2'(m);
        audDivSel = 1'(s);
        f = audFactor(m, s);
        settledMeasure(1, hi, lo);
        check(hi + lo == f, "R2 audio clock period", hi + lo, f);
        check(hi == lo, "R4 audio clock duty", hi, lo);
        settledMeasure(2, mh, ml);
        check(mh + ml == f, "R7 master clock period from audio clock", mh + ml, f);
      end
    end
    check(mclkOe === 1'b1, "R6 enable high in master mode", int'(mclkOe), 1);
  endtask

  task automatic testTerminal();
    int hi, lo, cnt;
    rateMode = 2'd3;
    sysDivSel = 2'd3;
    settledMeasure(0, hi, lo);
    @(negedge synthClk);
    while (sysClkOut !== 1'b0) @(negedge synthClk);
    while (sysClkOut !== 1'b1) @(negedge synthClk);
    cnt = 0;
    while (sysClkOut === 1'b1) begin
      cnt++;
      if (cnt == 5) sysDivSel = 2'd0;
      @(negedge synthClk);
    end
    check(cnt == 24, "R5 phase in progress keeps old length", cnt, 24);
    lo = 0;
    while (sysClkOut === 1'b0) begin lo++; @(negedge synthClk); end
    check(lo == 3, "R5 next phase takes new length", lo, 3);
    hi = 0;
    while (sysClkOut === 1'b1) begin hi++; @(negedge synthClk); end
    check(hi == 3, "R5 new length holds", hi, 3);
  endtask

  task automatic testSlave();
    int bad = 0;
    masterMode = 1'b1;
    mclkSrcOsc = 1'b1;
    repeat (20) @(negedge synthClk);
    masterMode = 1'b0;
    repeat (2) @(negedge synthClk);
    for (int i = 0; i < 100; i++) begin
      #1;
      if (mclkOut !== 1'b0 || mclkOe !== 1'b0) bad++;
      @(negedge synthClk);
    end
    check(bad == 0, "R6 slave mode keeps master clock off", bad, 0);
  endtask

  task automatic testOscFollow();
    int bad;
    masterMode = 1'b1;
    rateMode = 2'd1;
    audDivSel = 1'b0;
    mclkSrcOsc = 1'b1;
    repeat (150) @(negedge synthClk);
    followOsc(2, 1'b1, bad);
    check(bad == 0, "R8 master clock follows oscillator, audio select ignored", bad, 0);
  endtask

  task automatic testAux();
    int hi, lo, bad;
    auxSrcOsc = 1'b0;
    rateMode = 2'd2;
    sysDivSel = 2'd1;
    repeat (150) @(negedge synthClk);
    settledMeasure(3, hi, lo);
    check(hi + lo == 8 && hi == lo, "R9 aux clock carries system clock", hi + lo, 8);
    auxSrcOsc = 1'b1;
    repeat (150) @(negedge synthClk);
    followOsc(3, 1'b0, bad);
    check(bad == 0, "R9 aux clock follows oscillator", bad, 0);
    auxSrcOsc = 1'b0;
  endtask

  task automatic testGlitch();
    masterMode = 1'b1;
    rateMode = 2'd1;
    audDivSel = 1'b0;
    mclkSrcOsc = 1'b0;
    repeat (100) @(negedge synthClk);
    haveEdge = 1'b0;
    minPulse = 1000000;
    watchOn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      mclkSrcOsc = ~mclkSrcOsc;
      repeat (37 + i) @(negedge synthClk);
    end
    watchOn = 1'b0;
    check(minPulse >= OSC_HALF, "R10 no short pulse on source switch", int'(minPulse), OSC_HALF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testSysSweep();
    testAudSweep();
    testTerminal();
    testOscFollow();
    testSlave();
    testAux();
    testGlitch();
    finishRun();
  end
endmodule